// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from reset to a ready state by driving its command, address, bank, clock-enable and data-mask pins. Leaving reset, it keeps clock enable and the data mask high. It also holds a no-operation command on the pins for a stabilization window sized in clock cycles. The window size comes from the clock frequency and the required hold time in microseconds.

After the window it issues a precharge of every bank, then a configurable number of auto-refresh commands (never fewer than two) and one mode register load. A configuration input decides whether the mode load comes before or after the refreshes. A gap counter places a programmable number of no-operation cycles between consecutive commands. The mode word is assembled from configuration inputs for CAS latency, burst type, burst length and write burst mode, and is checked for reserved encodings before it is sent.

When the last command's gap has run out, a done flag rises and stays high until reset, and the memory controller takes over the pins. An illegal configuration stops the sequence before the mode load and raises an error flag instead.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted the pins show a no-operation ({cs_n,ras_n,cas_n,we_n} = 0111), address 0, bank 0, clock enable 1, data mask 1, and done and error are both 0.
- R2: After reset release only no-operation is driven for at least CLK_MHZ*HOLD_US cycles; the first command appears within four cycles after that count.
- R3: The first command is precharge-all: {cs_n,ras_n,cas_n,we_n} = 0010 with address bit AP_BIT (8) high and every other address bit 0.
- R4: Exactly max(REF_COUNT,2) auto-refresh commands (0001, address 0) are issued.
- R5: Exactly one mode register load (0000) is issued: right after the precharge when mode_first is 1, after the last refresh when it is 0.
- R6: The mode word carries burst length on addr[2:0], burst type on addr[3], CAS latency on addr[6:4], 0 on addr[8:7], and the write burst mode bit on the bank pin.
- R7: Exactly GAP_CYCLES no-operation cycles lie between any two consecutive commands.
- R8: Done rises GAP_CYCLES+1 cycles after the final command, then stays high with only no-operation driven until reset.
- R9: With an illegal configuration no mode load is issued, error rises GAP_CYCLES+1 cycles after the last command issued, done stays low, and only no-operation follows.
- R10: A configuration is legal only if CAS latency is 010 or 011 and burst length is 000 to 011, or 111 with burst type 0 (sequential full page).
- R11: Clock enable and data mask stay high during the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| cfg_mode_first | input | 1 | 1: mode load before the refreshes, 0: after them |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_burst_ilv | input | 1 | Burst type, 0 sequential, 1 interleaved |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_single_wr | input | 1 | Write burst mode bit placed on the bank pin |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | ADDR_W | Address pins |
| init_done | output | 1 | Initialization complete, sticky until reset |
| init_error | output | 1 | Illegal configuration detected, sequence stopped |

## Verification
Every pin is registered. A command, the done flag and the error flag therefore become visible on the cycle after the edge that chose them. That edge comes GAP_CYCLES+1 cycles after the previous command. The first command arrives roughly CLK_MHZ*HOLD_US cycles after release, plus two cycles for the reset synchronizer. The bench samples all outputs at the falling edge and records the cycle number of each command. It then compares spacings and flag arrival against GAP_CYCLES+1 and accepts the hold time within a four-cycle window, so it does not rely on the exact position of a register stage. Reset values are read while reset is held, a short delay after the asynchronous assertion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command code packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE  = 4'b0000,
    CMD_AREF  = 4'b0001,
    CMD_PALL  = 4'b0010,
    CMD_IDLE  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_READY = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [2:0] cas_lat;
    logic       burst_ilv;
    logic [2:0] burst_len;
    logic       single_wr;
  } mode_cfg_t;

  // legal: latency 2 or 3; length 1/2/4/8, or full page with sequential type
  function automatic logic mode_cfg_legal(input mode_cfg_t c);
    logic lat_ok;
    logic len_ok;
    lat_ok = (c.cas_lat == 3'b010) || (c.cas_lat == 3'b011);
    len_ok = (c.burst_len[2] == 1'b0) ||
             ((c.burst_len == 3'b111) && (c.burst_ilv == 1'b0));
    return lat_ok && len_ok;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  mode_cfg_t         cfg,
  output logic [ADDR_W-1:0] word,
  output logic              bank,
  output logic              legal
);

  always_comb begin
    word      = '0;
    word[2:0] = cfg.burst_len;
    word[3]   = cfg.burst_ilv;
    word[6:4] = cfg.cas_lat;
    // bits 8:7 select test modes and stay 0 for a normal load
    bank      = cfg.single_wr;
    legal     = mode_cfg_legal(cfg);
  end

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  sd_cmd_e           cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ba_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              ba,
  output logic              cke,
  output logic              dqm
);

  sd_cmd_e           cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ba_q, ba_d;
  logic              cke_q, dqm_q;

  always_comb begin
    cmd_d  = cmd_vld ? cmd_in  : CMD_IDLE;
    addr_d = cmd_vld ? addr_in : '0;
    ba_d   = cmd_vld ? ba_in   : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      ba_q   <= 1'b0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr = addr_q;
  assign ba   = ba_q;
  assign cke  = cke_q;
  assign dqm  = dqm_q;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned HOLD_US    = 200,
  parameter int unsigned REF_COUNT  = 2,
  parameter int unsigned GAP_CYCLES = 3,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned AP_BIT     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_first,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_burst_ilv,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_single_wr,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic              sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              init_error
);

  localparam int unsigned HOLD_CYCLES = (CLK_MHZ * HOLD_US < 1) ? 1 : CLK_MHZ * HOLD_US;
  localparam int unsigned REF_N       = (REF_COUNT < 2) ? 2 : REF_COUNT;
  localparam int unsigned STEPS       = REF_N + 2;
  localparam int unsigned STEP_W      = $clog2(STEPS + 1);
  localparam int unsigned CNT_MAX     = (HOLD_CYCLES > GAP_CYCLES) ? HOLD_CYCLES : GAP_CYCLES;
  localparam int unsigned CNT_W       = $clog2(CNT_MAX + 1);
  localparam logic [STEP_W-1:0] END_STEP  = STEP_W'(STEPS);
  localparam logic [STEP_W-1:0] MODE_LATE = STEP_W'(STEPS - 1);
  localparam logic [CNT_W-1:0]  HOLD_LD   = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0]  GAP_LD    = CNT_W'(GAP_CYCLES);

  // reset: asynchronous assertion, release through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mode_cfg_t         mode_cfg;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_bank;
  logic              mode_legal;

  assign mode_cfg = '{cas_lat:   cfg_cas_lat,
                      burst_ilv: cfg_burst_ilv,
                      burst_len: cfg_burst_len,
                      single_wr: cfg_single_wr};

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .cfg   (mode_cfg),
    .word  (mode_word),
    .bank  (mode_bank),
    .legal (mode_legal)
  );

  logic tmr_load, tmr_zero;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(HOLD_LD)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (tmr_load),
    .load_val (GAP_LD),
    .zero     (tmr_zero)
  );

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  sd_cmd_e           step_cmd;
  logic              cmd_vld;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cmd_ba;

  // which command belongs to the current step
  always_comb begin
    if (step_q == '0) begin
      step_cmd = CMD_PALL;
    end else if (cfg_mode_first) begin
      step_cmd = (step_q == STEP_W'(1)) ? CMD_MODE : CMD_AREF;
    end else begin
      step_cmd = (step_q == MODE_LATE) ? CMD_MODE : CMD_AREF;
    end
  end

  always_comb begin
    cmd_addr = '0;
    cmd_ba   = 1'b0;
    case (step_cmd)
      CMD_PALL: cmd_addr[AP_BIT] = 1'b1;
      CMD_MODE: begin
        cmd_addr = mode_word;
        cmd_ba   = mode_bank;
      end
      default: ;
    endcase
  end

  // next-state process
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cmd_vld  = 1'b0;
    tmr_load = 1'b0;
    if ((state_q == ST_RUN) && tmr_zero) begin
      if (step_q == END_STEP) begin
        state_d = ST_READY;
      end else if ((step_cmd == CMD_MODE) && !mode_legal) begin
        state_d = ST_FAULT;
      end else begin
        cmd_vld  = 1'b1;
        tmr_load = 1'b1;
        step_d   = step_q + STEP_W'(1);
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_RUN;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  sdram_cmd_reg #(.ADDR_W(ADDR_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cmd_vld (cmd_vld),
    .cmd_in  (step_cmd),
    .addr_in (cmd_addr),
    .ba_in   (cmd_ba),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .addr    (sd_addr),
    .ba      (sd_ba),
    .cke     (sd_cke),
    .dqm     (sd_dqm)
  );

  assign init_done  = (state_q == ST_READY);
  assign init_error = (state_q == ST_FAULT);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned GAP_CYCLES = 3,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned AP_BIT     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              cke,
  input logic              dqm,
  input logic              done,
  input logic              fault
);

  localparam int unsigned GW = $clog2(GAP_CYCLES + 2);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_CYCLES);
  localparam logic [GW-1:0] SAT_V = GW'(GAP_CYCLES + 1);

  logic          is_idle;
  logic          seen_q;
  logic [GW-1:0] since_q;

  assign is_idle = (cmd == 4'b0111);

  // idle cycles since the last command, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      since_q <= '0;
    end else if (!is_idle) begin
      seen_q  <= 1'b1;
      since_q <= '0;
    end else if (since_q != SAT_V) begin
      since_q <= since_q + GW'(1);
    end
  end

  assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0111) || (cmd == 4'b0010) || (cmd == 4'b0001) || (cmd == 4'b0000));

  assert_pall_ap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[AP_BIT]);

  assert_mode_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> ((addr[8:7] == 2'b00) &&
                          ((addr[6:4] == 3'b010) || (addr[6:4] == 3'b011))));

  assert_cmd_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_idle && seen_q) |-> (since_q == GAP_V));

  assert_done_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (seen_q && since_q == GAP_V));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && is_idle));

  assert_fault_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (seen_q && since_q == GAP_V));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && is_idle && !done));

  assert_pins_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dqm);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .GAP_CYCLES (GAP_CYCLES),
  .ADDR_W     (ADDR_W),
  .AP_BIT     (AP_BIT)
) u_init_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cmd   ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .addr  (sd_addr),
  .cke   (sd_cke),
  .dqm   (sd_dqm),
  .done  (init_done),
  .fault (init_error)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 2;
  localparam int HOLD_US    = 10;
  localparam int HOLD       = CLK_MHZ * HOLD_US;
  localparam int REFS       = 3;
  localparam int GAP        = 2;
  localparam int ADDR_W     = 9;

  localparam logic [3:0] C_IDLE = 4'b0111;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_MODE = 4'b0000;

  typedef struct packed {
    logic       mf;
    logic [2:0] cl;
    logic       bt;
    logic [2:0] bl;
    logic       sw;
    logic       ok;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd2, 1'b0, 3'd3, 1'b0, 1'b1},  // late mode, CL2, length 8
    '{1'b1, 3'd3, 1'b1, 3'd2, 1'b1, 1'b1},  // early mode, CL3 interleaved
    '{1'b0, 3'd3, 1'b0, 3'd7, 1'b0, 1'b1},  // full page sequential (R10 legal)
    '{1'b1, 3'd2, 1'b1, 3'd7, 1'b0, 1'b0},  // full page interleaved (R10 illegal)
    '{1'b0, 3'd1, 1'b0, 3'd0, 1'b1, 1'b0},  // reserved latency 1
    '{1'b1, 3'd4, 1'b0, 3'd1, 1'b0, 1'b0},  // reserved latency 4
    '{1'b0, 3'd2, 1'b0, 3'd5, 1'b0, 1'b0},  // reserved length code
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b1}   // early mode, single
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mode_first, cfg_burst_ilv, cfg_single_wr;
  logic [2:0] cfg_cas_lat, cfg_burst_len;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm, sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic init_done, init_error;

  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US), .REF_COUNT(REFS),
    .GAP_CYCLES(GAP), .ADDR_W(ADDR_W), .AP_BIT(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode_first(cfg_mode_first),
    .cfg_cas_lat(cfg_cas_lat), .cfg_burst_ilv(cfg_burst_ilv),
    .cfg_burst_len(cfg_burst_len), .cfg_single_wr(cfg_single_wr),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .init_done(init_done), .init_error(init_error)
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input string req, input string what, input bit cond,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_reset_state(input string tag);
    chk("R1", {tag, " command idle"}, pins() == C_IDLE, int'(pins()), int'(C_IDLE));
    chk("R1", {tag, " address/bank zero"}, (sd_addr == '0) && !sd_ba, int'(sd_addr), 0);
    chk("R1", {tag, " cke/dqm high"}, sd_cke && sd_dqm, int'({sd_cke, sd_dqm}), 3);
    chk("R1", {tag, " flags low"}, !init_done && !init_error,
        int'({init_done, init_error}), 0);
  endtask

  function automatic logic [3:0] exp_code(input vec_t v, input int i);
    if (i == 0) return C_PALL;
    if (v.mf) return (i == 1) ? C_MODE : C_AREF;
    return (i == REFS + 1) ? C_MODE : C_AREF;
  endfunction

  task automatic run_case(input int idx, input vec_t v);
    int n_cmd, first_cyc, done_cyc, err_cyc, mism, gap_bad, exp_n, mi, last;
    int cyc_log [16];
    logic [3:0] code_log [16];
    logic [ADDR_W-1:0] addr_log [16];
    logic ba_log [16];
    bit pins_ok, quiet_ok;
    string tag;
    tag = $sformatf("case%0d", idx);
    n_cmd = 0; first_cyc = -1; done_cyc = -1; err_cyc = -1;
    pins_ok = 1'b1; quiet_ok = 1'b1;
    @(negedge clk);
    cfg_mode_first = v.mf; cfg_cas_lat = v.cl; cfg_burst_ilv = v.bt;
    cfg_burst_len = v.bl; cfg_single_wr = v.sw;
    rst_n = 1'b0;
    #1;
    check_reset_state(tag);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 1; cyc < 400; cyc++) begin
      @(negedge clk);
      if (!sd_cke || !sd_dqm) pins_ok = 1'b0;
      if (pins() != C_IDLE) begin
        if (done_cyc >= 0 || err_cyc >= 0) quiet_ok = 1'b0;
        else if (n_cmd < 16) begin
          cyc_log[n_cmd] = cyc; code_log[n_cmd] = pins();
          addr_log[n_cmd] = sd_addr; ba_log[n_cmd] = sd_ba;
          if (n_cmd == 0) first_cyc = cyc;
          n_cmd++;
        end
      end
      if (done_cyc >= 0 && !init_done) quiet_ok = 1'b0;
      if (err_cyc >= 0 && (!init_error || init_done)) quiet_ok = 1'b0;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (init_error && err_cyc < 0) err_cyc = cyc;
      if ((done_cyc >= 0 && cyc >= done_cyc + 12) ||
          (err_cyc >= 0 && cyc >= err_cyc + 12)) break;
    end

    chk("R2", {tag, " hold window"}, first_cyc >= HOLD && first_cyc <= HOLD + 4,
        first_cyc, HOLD);
    chk("R3", {tag, " first command precharge-all"},
        n_cmd > 0 && code_log[0] == C_PALL && addr_log[0] == 9'h100,
        n_cmd > 0 ? int'({code_log[0], addr_log[0]}) : -1, int'({C_PALL, 9'h100}));
    exp_n = v.ok ? REFS + 2 : (v.mf ? 1 : REFS + 1);
    chk("R4", {tag, " command count"}, n_cmd == exp_n, n_cmd, exp_n);
    mism = 0; gap_bad = 0;
    for (int i = 0; i < n_cmd && i < 16; i++) begin
      if (code_log[i] != exp_code(v, i)) mism++;
      if (code_log[i] == C_AREF && (addr_log[i] != '0 || ba_log[i])) mism++;
      if (i > 0 && cyc_log[i] - cyc_log[i-1] != GAP + 1) gap_bad++;
    end
    chk("R5", {tag, " command order"}, mism == 0, mism, 0);
    chk("R7", {tag, " command spacing"}, gap_bad == 0, gap_bad, 0);
    last = (n_cmd > 0) ? cyc_log[((n_cmd > 16) ? 16 : n_cmd) - 1] : 0;
    if (v.ok) begin
      mi = v.mf ? 1 : REFS + 1;
      chk("R6", {tag, " mode word"},
          n_cmd > mi && addr_log[mi] == {2'b00, v.cl, v.bt, v.bl} && ba_log[mi] == v.sw,
          n_cmd > mi ? int'({ba_log[mi], addr_log[mi]}) : -1,
          int'({v.sw, 2'b00, v.cl, v.bt, v.bl}));
      chk("R8", {tag, " done timing"}, done_cyc == last + GAP + 1 && err_cyc < 0,
          done_cyc, last + GAP + 1);
      chk("R8", {tag, " done sticky and quiet"}, quiet_ok, int'(quiet_ok), 1);
      chk("R10", {tag, " legal config accepted"}, err_cyc < 0, err_cyc, -1);
    end else begin
      chk("R9", {tag, " error timing (R10 reject)"}, err_cyc == last + GAP + 1,
          err_cyc, last + GAP + 1);
      chk("R9", {tag, " no done, quiet after error"}, done_cyc < 0 && quiet_ok,
          done_cyc, -1);
    end
    chk("R11", {tag, " cke/dqm held high"}, pins_ok, int'(pins_ok), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_mode_first = 1'b0; cfg_cas_lat = 3'd2; cfg_burst_ilv = 1'b0;
    cfg_burst_len = 3'd0; cfg_single_wr = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("initial");

    for (int k = 0; k < NV; k++) run_case(k, VECS[k]);

    // directed: done still high long after completion, then cleared by reset
    run_case(100, VECS[0]);
    repeat (60) @(negedge clk);
    chk("R8", "done held after 60 idle cycles", init_done && pins() == C_IDLE,
        int'(init_done), 1);
    rst_n = 1'b0;
    #1;
    check_reset_state("reset after done");

    // directed: reset in the middle of the refresh phase
    @(negedge clk);
    rst_n = 1'b1;
    repeat (HOLD + 8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-sequence reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", "idle shortly after re-release", pins() == C_IDLE && !init_done,
        int'(pins()), int'(C_IDLE));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule